// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches an I2C bus whose SCL and SDA lines have already been synchronised to the local clock. It finds start, repeated-start and stop conditions, shifts in the address byte(s) that follow a start, and decides whether this device is the target. It then tells the pad logic whether to pull SDA low during the acknowledge clock. In 7-bit mode the first byte is compared against four programmable ID registers in parallel. In 10-bit mode a single address is used, split across ID0 and ID1, and the standard two-byte framing is followed.

After a successful match the block keeps producing acknowledge decisions for the data bytes of a write transfer. A force-NACK input lets the host reject a byte, for example a bad checksum at the end of a message. ID register writes arrive on a simple write strobe. When a write lands while a transfer is in progress, it is parked and applied once the bus is idle again. The transfer underway therefore always sees a stable set of IDs.

Top module: `i2c_addr_recog`

## Requirements
- R1: After reset `busy`, `addr_match` and `ack_drive` are low and all ID registers hold 0x00, so a first address byte 0x01 is acknowledged with `match_id`=0 and `rd_dir`=1.
- R2: SDA falling while SCL stays high starts an address phase and raises `busy` one clock after it is sampled. SDA rising while SCL stays high returns the block to idle and lowers `busy`.
- R3: In 7-bit mode, bits [7:1] of the first byte after a start are compared with bits [7:1] of each ID register, and ID bit 0 is ignored. On a hit, `addr_match` pulses for one clock and `rd_dir` takes byte bit 0 (1 = read). `ack_drive` is high from the SCL fall that ends bit 8 until the SCL fall that ends the acknowledge clock.
- R4: When several IDs match, `match_id` reports the lowest index.
- R5: An address byte that matches nothing gives no `addr_match` pulse, and `ack_drive` stays low for it and for every later byte until the next start.
- R6: A repeated start, with no stop before it, restarts address recognition from the first byte.
- R7: In 10-bit mode the address is {ID1[2:0], ID0[7:1]}. A first byte of 11110 A9 A8 0 is acknowledged without an `addr_match` pulse. A second byte equal to A7..A0 is acknowledged with `addr_match`, `match_id`=0 and `rd_dir`=0. A wrong second byte is not acknowledged.
- R8: In 10-bit mode, a first byte of 11110 A9 A8 1 is acknowledged, with `addr_match` and `rd_dir`=1, only if a full 10-bit write match has happened since the last stop. Otherwise it is not acknowledged.
- R9: In 10-bit mode ID2 and ID3 take no part in matching, and nothing is acknowledged unless ID1[7:3] is 11110.
- R10: After a match with `rd_dir`=0, each data byte is acknowledged unless `force_nack` is high. After a match with `rd_dir`=1, `ack_drive` stays low for data bytes.
- R11: An ID write (`id_we` with `id_sel` and `id_wdata`) while `busy` is low takes effect on the next clock. A write while `busy` is high is held and applied when `busy` falls, so the transfer in progress still matches against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| ten_bit_en | input | 1 | 1 selects the single 10-bit address held in ID0/ID1 |
| force_nack | input | 1 | 1 refuses acknowledge on data bytes of a write |
| id_we | input | 1 | ID register write strobe |
| id_sel | input | 2 | ID register index for the write |
| id_wdata | input | 8 | ID register write value |
| busy | output | 1 | A transfer is in progress (start seen, no stop yet) |
| addr_match | output | 1 | One-clock pulse when this device is addressed |
| match_id | output | 2 | Index of the matching ID, held until the next match |
| rd_dir | output | 1 | Direction of the last match, 1 = read |
| ack_drive | output | 1 | Pull SDA low for the current acknowledge clock |

## Verification
Every result is registered on the first clock edge that samples the bus event. A sampled start or stop changes `busy` on the next edge. A sampled SCL fall ending bit 8 sets `addr_match` and `ack_drive` on that same edge, and `ack_drive` clears on the edge that samples the fall ending the acknowledge clock. An idle ID write is visible to the comparison from the following clock. A behavioural model in the bench applies these latencies edge by edge, and the outputs are compared with it on every falling clock edge. The directed checks read `ack_drive` and the captured match data several clocks into the SCL-high half of the acknowledge bit, well after the result is due.

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog #(
  parameter int NUM_IDS = 4,
  parameter int IDX_W   = $clog2(NUM_IDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             ten_bit_en,
  input  logic             force_nack,
  input  logic             id_we,
  input  logic [IDX_W-1:0] id_sel,
  input  logic [7:0]       id_wdata,
  output logic             busy,
  output logic             addr_match,
  output logic [IDX_W-1:0] match_id,
  output logic             rd_dir,
  output logic             ack_drive
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_LOW, ST_DATA, ST_SKIP} st_t;

  st_t              st_q, nxt_st;
  logic             scl_q, sda_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_ack_q, ten_ok_q;
  logic [BYTE_W-1:0] id_q [NUM_IDS];
  logic             pend_v;
  logic [IDX_W-1:0] pend_sel;
  logic [BYTE_W-1:0] pend_dat;

  logic start_c, stop_c, rise_c, fall_c, byte_end, ack_end;
  logic [NUM_IDS-1:0] hit_v;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic hdr_ok, low_ok;
  logic dec_ack, dec_match, dec_rd, dec_ten;
  logic [IDX_W-1:0] dec_idx;

  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_c   = scl_i & ~scl_q;
  assign fall_c   = ~scl_i & scl_q;
  assign busy     = (st_q != ST_IDLE);
  assign byte_end = busy & fall_c & ~in_ack_q & (cnt_q == CNT_W'(BYTE_W));
  assign ack_end  = fall_c & in_ack_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_cmp
    assign hit_v[g] = (id_q[g][7:1] == sh_q[7:1]);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--)
      if (hit_v[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  assign hdr_ok = (id_q[1][7:3] == TEN_HDR) && (sh_q[7:1] == {TEN_HDR, id_q[1][2:1]});
  assign low_ok = (sh_q == {id_q[1][0], id_q[0][7:1]});

  always_comb begin
    dec_ack   = 1'b0;
    dec_match = 1'b0;
    dec_idx   = '0;
    dec_rd    = 1'b0;
    dec_ten   = 1'b0;
    nxt_st    = ST_SKIP;
    case (st_q)
      ST_HDR:
        if (ten_bit_en) begin
          if (hdr_ok && !sh_q[0]) begin
            dec_ack = 1'b1;
            nxt_st  = ST_LOW;
          end else if (hdr_ok && ten_ok_q) begin
            dec_ack   = 1'b1;
            dec_match = 1'b1;
            dec_rd    = 1'b1;
            nxt_st    = ST_DATA;
          end
        end else if (hit_any) begin
          dec_ack   = 1'b1;
          dec_match = 1'b1;
          dec_idx   = hit_idx;
          dec_rd    = sh_q[0];
          nxt_st    = ST_DATA;
        end
      ST_LOW:
        if (low_ok) begin
          dec_ack   = 1'b1;
          dec_match = 1'b1;
          dec_ten   = 1'b1;
          nxt_st    = ST_DATA;
        end
      ST_DATA: begin
        dec_ack = ~rd_dir & ~force_nack;
        nxt_st  = ST_DATA;
      end
      ST_IDLE: nxt_st = ST_IDLE;
      default: nxt_st = ST_SKIP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      sh_q       <= '0;
      cnt_q      <= '0;
      in_ack_q   <= 1'b0;
      ten_ok_q   <= 1'b0;
      addr_match <= 1'b0;
      match_id   <= '0;
      rd_dir     <= 1'b0;
      ack_drive  <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      addr_match <= 1'b0;
      if (start_c) begin
        st_q      <= ST_HDR;
        cnt_q     <= '0;
        in_ack_q  <= 1'b0;
        ack_drive <= 1'b0;
      end else if (stop_c) begin
        st_q      <= ST_IDLE;
        cnt_q     <= '0;
        in_ack_q  <= 1'b0;
        ack_drive <= 1'b0;
        ten_ok_q  <= 1'b0;
      end else begin
        if (busy && rise_c && !in_ack_q && cnt_q != CNT_W'(BYTE_W)) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end
        if (byte_end) begin
          in_ack_q   <= 1'b1;
          ack_drive  <= dec_ack;
          addr_match <= dec_match;
          st_q       <= nxt_st;
          if (dec_match) begin
            match_id <= dec_idx;
            rd_dir   <= dec_rd;
          end
          if (dec_ten) ten_ok_q <= 1'b1;
        end
        if (ack_end) begin
          in_ack_q  <= 1'b0;
          ack_drive <= 1'b0;
          cnt_q     <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_sel <= '0;
      pend_dat <= '0;
      for (int i = 0; i < NUM_IDS; i++) id_q[i] <= '0;
    end else if (busy) begin
      if (id_we) begin
        pend_v   <= 1'b1;
        pend_sel <= id_sel;
        pend_dat <= id_wdata;
      end
    end else begin
      pend_v <= 1'b0;
      for (int i = 0; i < NUM_IDS; i++) begin
        if (id_we && id_sel == IDX_W'(i))          id_q[i] <= id_wdata;
        else if (pend_v && pend_sel == IDX_W'(i))  id_q[i] <= pend_dat;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk #(
  parameter int NUM_IDS = 4,
  parameter int IDX_W   = $clog2(NUM_IDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             ten_bit_en,
  input logic             busy,
  input logic             addr_match,
  input logic [IDX_W-1:0] match_id,
  input logic             ack_drive
);
  p_match_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !addr_match);

  p_match_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> ack_drive);

  p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> !$past(scl_i));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ack_drive && !addr_match));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> busy);

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !busy);

  p_ten_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_match && ten_bit_en) |-> (match_id == '0));
endmodule

bind i2c_addr_recog i2c_addr_recog_chk #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ten_bit_en(ten_bit_en),
  .busy(busy), .addr_match(addr_match), .match_id(match_id), .ack_drive(ack_drive)
);

// File: tb/i2c_addr_recog_test.sv
`timescale 1ns/1ps
module i2c_addr_recog_test;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic ten = 1'b0, fnack = 1'b0, we = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wdat = '0;
  logic busy, amatch, rd, ackd;
  logic [1:0] mid;

  int total = 0, bad = 0;
  int n_match = 0, last_idx = 0, last_rd = 0;

  always #2.5 clk = ~clk;

  i2c_addr_recog uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .ten_bit_en(ten),
    .force_nack(fnack), .id_we(we), .id_sel(sel), .id_wdata(wdat),
    .busy(busy), .addr_match(amatch), .match_id(mid), .rd_dir(rd), .ack_drive(ackd)
  );

  // behavioural reference: 0 idle, 1 first byte, 2 second 10-bit byte, 3 data, 4 ignore
  int m_st, m_bits, m_byte, m_ackph, m_ten_ok;
  int m_busy, m_match, m_idx, m_rd, m_ack;
  int m_id[4];
  int m_pend, m_psel, m_pdat, m_pscl, m_psda;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_bits = 0; m_byte = 0; m_ackph = 0; m_ten_ok = 0;
      m_match = 0; m_idx = 0; m_rd = 0; m_ack = 0; m_pend = 0; m_psel = 0; m_pdat = 0;
      m_pscl = 1; m_psda = 1;
      foreach (m_id[i]) m_id[i] = 0;
    end else begin
      bit was_busy;
      int a10;
      was_busy = (m_st != 0);
      m_match = 0;
      if (!was_busy) begin
        if (m_pend != 0) m_id[m_psel] = m_pdat;
        if (we) m_id[sel] = wdat;
        m_pend = 0;
      end else if (we) begin
        m_pend = 1; m_psel = sel; m_pdat = wdat;
      end
      if (scl && m_pscl && m_psda && !sda) begin
        m_st = 1; m_bits = 0; m_ackph = 0; m_ack = 0;
      end else if (scl && m_pscl && !m_psda && sda) begin
        m_st = 0; m_bits = 0; m_ackph = 0; m_ack = 0; m_ten_ok = 0;
      end else if (was_busy) begin
        if (scl && !m_pscl && m_ackph == 0 && m_bits < 8) begin
          m_byte = ((m_byte << 1) | sda) & 255;
          m_bits++;
        end else if (!scl && m_pscl && m_ackph != 0) begin
          m_ackph = 0; m_ack = 0; m_bits = 0;
        end else if (!scl && m_pscl && m_bits == 8) begin
          int nst, hit;
          m_ackph = 1; m_ack = 0; nst = 4; hit = -1;
          a10 = ((m_id[1] & 7) << 7) | (m_id[0] >> 1);
          if (m_st == 1 && ten) begin
            if ((m_id[1] >> 3) == 30 && (m_byte >> 1) == (120 | (a10 >> 8))) begin
              if ((m_byte & 1) == 0) begin m_ack = 1; nst = 2; end
              else if (m_ten_ok != 0) begin m_ack = 1; m_match = 1; m_idx = 0; m_rd = 1; nst = 3; end
            end
          end else if (m_st == 1) begin
            for (int i = 3; i >= 0; i--) if ((m_id[i] >> 1) == (m_byte >> 1)) hit = i;
            if (hit >= 0) begin m_ack = 1; m_match = 1; m_idx = hit; m_rd = m_byte & 1; nst = 3; end
          end else if (m_st == 2) begin
            if (m_byte == (a10 & 255)) begin
              m_ack = 1; m_match = 1; m_idx = 0; m_rd = 0; m_ten_ok = 1; nst = 3;
            end
          end else if (m_st == 3) begin
            m_ack = (m_rd == 0 && !fnack) ? 1 : 0; nst = 3;
          end
          m_st = nst;
        end
      end
      m_pscl = scl; m_psda = sda;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 busy vs model", busy, (m_st != 0) ? 1 : 0);
    chk("R3/R5 addr_match vs model", amatch, m_match);
    chk("R4 match_id vs model", mid, m_idx);
    chk("R3 rd_dir vs model", rd, m_rd);
    chk("R10 ack_drive vs model", ackd, m_ack);
    if (amatch) begin n_match++; last_idx = mid; last_rd = rd; end
  end

  task automatic waitn(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); scl = 1; sda = 1; waitn(H); sda = 0; waitn(H); scl = 0; waitn(H); endtask
  task automatic bus_rstart(); scl = 0; sda = 1; waitn(H); scl = 1; waitn(H); sda = 0; waitn(H); scl = 0; waitn(H); endtask
  task automatic bus_stop(); scl = 0; sda = 0; waitn(H); scl = 1; waitn(H); sda = 1; waitn(H); endtask
  task automatic send(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; waitn(H); scl = 1; waitn(H); scl = 0; waitn(H);
    end
    sda = 1; waitn(H); scl = 1; waitn(H);
    ack = ackd;
    scl = 0; waitn(H);
  endtask
  task automatic wr_id(input int s, input int d);
    sel = 2'(s); wdat = 8'(d); we = 1; waitn(1); we = 0; waitn(1);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, n0;
    waitn(3); rst_n = 1; waitn(2);
    chk("R1 busy after reset", busy, 0);
    chk("R1 ack_drive after reset", ackd, 0);
    chk("R1 addr_match after reset", amatch, 0);
    bus_start();
    chk("R2 busy after start", busy, 1);
    n0 = n_match; send(8'h01, a);
    chk("R1 cleared ID0 acks 0x01", a, 1);
    chk("R1 match count", n_match, n0 + 1);
    chk("R1 index", last_idx, 0);
    chk("R1 read dir", last_rd, 1);
    bus_stop();
    chk("R2 busy after stop", busy, 0);

    wr_id(0, 8'h20); wr_id(1, 8'h42); wr_id(2, 8'h86); wr_id(3, 8'h43);
    bus_start(); send(8'h86, a);
    chk("R3 ack on ID2", a, 1); chk("R3 index", last_idx, 2); chk("R3 write dir", last_rd, 0);
    send(8'h55, a); chk("R10 data ack", a, 1);
    fnack = 1; send(8'hAA, a); chk("R10 forced nack", a, 0); fnack = 0;
    bus_stop();

    bus_start(); send(8'h43, a);
    chk("R4 lowest index wins", last_idx, 1); chk("R4 ack", a, 1); chk("R3 read dir", last_rd, 1);
    send(8'hFF, a); chk("R10 no ack on read data", a, 0);
    bus_stop();

    bus_start(); n0 = n_match; send(8'h7E, a);
    chk("R5 nack unmatched", a, 0); chk("R5 no pulse", n_match, n0);
    send(8'h86, a); chk("R5 later byte ignored", a, 0);
    bus_rstart(); send(8'h20, a);
    chk("R6 repeated start ack", a, 1); chk("R6 index", last_idx, 0);
    bus_stop();

    bus_start(); send(8'h86, a);
    wr_id(2, 8'h10);
    bus_rstart(); send(8'h86, a);
    chk("R11 old ID kept during transfer", a, 1);
    bus_stop();
    bus_start(); send(8'h86, a); chk("R11 held write applied", a, 0);
    bus_rstart(); send(8'h10, a); chk("R11 new ID matches", a, 1); chk("R11 index", last_idx, 2);
    bus_stop();

    ten = 1; wr_id(0, 8'h4A); wr_id(1, 8'hF5);
    bus_start(); n0 = n_match; send(8'hF4, a);
    chk("R7 header ack", a, 1); chk("R7 no pulse on header", n_match, n0);
    send(8'hA5, a);
    chk("R7 low byte ack", a, 1); chk("R7 pulse", n_match, n0 + 1);
    chk("R7 index", last_idx, 0); chk("R7 write dir", last_rd, 0);
    bus_rstart(); send(8'hF5, a);
    chk("R8 read header ack", a, 1); chk("R8 read dir", last_rd, 1);
    bus_stop();
    bus_start(); send(8'hF5, a); chk("R8 read header refused", a, 0); bus_stop();
    bus_start(); send(8'hF4, a); send(8'hA4, a); chk("R7 wrong low byte", a, 0); bus_stop();
    bus_start(); send(8'h10, a); chk("R9 ID2 ignored in 10-bit", a, 0); bus_stop();
    wr_id(1, 8'h05);
    bus_start(); send(8'hF4, a); chk("R9 bad ID1 prefix", a, 0); bus_stop();

    waitn(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule